// File: doc/BRIEF.md
# External Interrupt Request Flag Controller

The block watches eight external interrupt request lines and holds one sticky status flag for each. For every channel a 2-bit sense field chooses what sets its flag: a low level, a falling edge, a rising edge or either edge. Each line first passes through a two-flop synchroniser. Edges are found by comparing the synchronised level with a registered copy of it. The edge detector is primed after reset, so releasing reset never reports an edge.

The flags are presented as one 8-bit status register on a small CPU register bus, with channel n at bit n. They are also driven out as per-channel pending lines. A flag clears in three ways:
- Software writes 0 to its bit, but only after a read of the register saw that bit at 1.
- A CPU exception acknowledge for the channel clears it. In low-level mode this happens only when the synchronised input is already high.
- A transfer-controller acknowledge clears it, unless the disable-clear qualifier is high.

When a set condition and a clear condition meet on the same channel in the same cycle, the set wins.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset every flag is 0, so `pending` and the value read from the register are both 8'h00.
- R2: Sense code 2'b00 selects low level: the flag sets while the synchronised input is low. A low input becomes visible on `pending` three clock edges after it is applied, and not at two.
- R3: Sense code 2'b01 sets the flag on a high-to-low transition, 2'b10 on a low-to-high transition, and 2'b11 on either transition. Any other transition leaves the flag unchanged.
- R4: An input held low through reset and after its release produces no edge, so an edge-mode flag stays 0.
- R5: Writing 1 to a flag bit never clears it. Such a write also cancels any earlier read permission, so a following write of 0 with no new read leaves the flag at 1.
- R6: A write of 0 clears flag n only if a read since the last write to bit n returned bit n as 1. Writes of 0 with no such read, or after a read that returned bit n as 0, leave the flag at 1.
- R7: A CPU exception acknowledge for channel n clears flag n when that channel's sense code is an edge mode (01, 10 or 11).
- R8: In low-level mode a CPU exception acknowledge clears flag n only if the synchronised input n is high. While the input is low, the flag stays at 1.
- R9: A transfer-controller acknowledge for channel n clears flag n when `xfer_noclr` is 0, and has no effect when it is 1.
- R10: If a set condition and any clear condition for the same channel fall in the same cycle, the flag stays at 1.
- R11: `reg_rdata` shows the current flags combinationally whenever `reg_cs` is high, with channel n at bit n. `pending` always equals the flags. A register write takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Raw external request lines, channel n at bit n |
| sense_cfg | input | 16 | Sense code of channel n at bits 2n+1:2n (00 low, 01 fall, 10 rise, 11 both) |
| reg_cs | input | 1 | Register access select |
| reg_we | input | 1 | 1 for a write, 0 for a read, while `reg_cs` is high |
| reg_wdata | input | 8 | Write data; a 0 bit asks to clear that flag |
| reg_rdata | output | 8 | Current flags while `reg_cs` is high, else 0 |
| cpu_ack | input | 8 | CPU exception acknowledge, one bit per channel |
| xfer_ack | input | 8 | Transfer-controller acknowledge, one bit per channel |
| xfer_noclr | input | 1 | Disable-clear qualifier for `xfer_ack` |
| pending | output | 8 | Per-channel flag outputs |

## Verification
The bench builds the block with its defaults: eight channels and two synchroniser stages. Two stages make the set latency a fixed three edges, which the bench checks on both sides. Eight channels let each bit position be checked at its own place, including bit 7. Running the four sense codes on different channels at the same moment shows that one shared transition sets only the channels whose code matches it.

// File: rtl/irqf_pkg.sv
`timescale 1ns/1ps
package irqf_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  // Set condition for one channel from its mode, current and previous level.
  // Edges count only once the detector is primed.
  function automatic logic sense_hit(sense_e mode, logic now, logic was, logic primed);
    logic fall_e, rise_e;
    fall_e = primed & was & ~now;
    rise_e = primed & ~was & now;
    case (mode)
      SENSE_LOW:  return ~now;
      SENSE_FALL: return fall_e;
      SENSE_RISE: return rise_e;
      default:    return fall_e | rise_e;
    endcase
  endfunction

  // Whether an exception acknowledge may clear a flag in this mode.
  function automatic logic ack_allowed(sense_e mode, logic now);
    return (mode == SENSE_LOW) ? now : 1'b1;
  endfunction

endpackage

// File: rtl/irqf_sync.sv
`timescale 1ns/1ps
module irqf_sync #(
  parameter int N_CH   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] raw,
  output logic [N_CH-1:0] lvl,
  output logic [N_CH-1:0] lvl_q,
  output logic            primed
);
  localparam int WARM_W = STAGES + 1;

  logic [N_CH-1:0]   stg [STAGES];
  logic [WARM_W-1:0] warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '1;
    end else begin
      stg[0] <= raw;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign lvl = stg[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '1;
      warm  <= '0;
    end else begin
      lvl_q <= lvl;
      warm  <= {warm[WARM_W-2:0], 1'b1};
    end
  end

  assign primed = warm[WARM_W-1];

endmodule

// File: rtl/irqf_detect.sv
`timescale 1ns/1ps
module irqf_detect
  import irqf_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic [2*N_CH-1:0] sense_cfg,
  input  logic [N_CH-1:0]   lvl,
  input  logic [N_CH-1:0]   lvl_q,
  input  logic              primed,
  output logic [N_CH-1:0]   set_evt
);
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    sense_e mode;
    assign mode       = sense_e'(sense_cfg[2*i +: 2]);
    assign set_evt[i] = sense_hit(mode, lvl[i], lvl_q[i], primed);
  end
endmodule

// File: rtl/irqf_flag_bank.sv
`timescale 1ns/1ps
module irqf_flag_bank
  import irqf_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*N_CH-1:0] sense_cfg,
  input  logic [N_CH-1:0]   lvl,
  input  logic [N_CH-1:0]   set_evt,
  input  logic              rd_evt,
  input  logic              wr_evt,
  input  logic [N_CH-1:0]   wdata,
  input  logic [N_CH-1:0]   cpu_ack,
  input  logic [N_CH-1:0]   xfer_ack,
  input  logic              xfer_noclr,
  output logic [N_CH-1:0]   flags,
  output logic [N_CH-1:0]   armed,
  output logic [N_CH-1:0]   clr_any
);
  logic [N_CH-1:0] flag_nxt;
  logic [N_CH-1:0] arm_nxt;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    sense_e mode;
    logic   hw_clr, sw_clr, arm_base;

    assign mode   = sense_e'(sense_cfg[2*i +: 2]);
    assign hw_clr = (cpu_ack[i] & ack_allowed(mode, lvl[i]))
                  | (xfer_ack[i] & ~xfer_noclr);
    assign sw_clr = wr_evt & ~wdata[i] & armed[i];
    assign clr_any[i]  = hw_clr | sw_clr;
    assign flag_nxt[i] = set_evt[i] | (flags[i] & ~clr_any[i]);

    always_comb begin
      arm_base = wr_evt ? 1'b0 : armed[i];
      if (rd_evt && flags[i]) arm_base = 1'b1;
    end
    assign arm_nxt[i] = arm_base & flag_nxt[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      armed <= '0;
    end else begin
      flags <= flag_nxt;
      armed <= arm_nxt;
    end
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
`timescale 1ns/1ps
module irq_flag_ctrl #(
  parameter int N_CH        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   irq_in,
  input  logic [2*N_CH-1:0] sense_cfg,
  input  logic              reg_cs,
  input  logic              reg_we,
  input  logic [N_CH-1:0]   reg_wdata,
  output logic [N_CH-1:0]   reg_rdata,
  input  logic [N_CH-1:0]   cpu_ack,
  input  logic [N_CH-1:0]   xfer_ack,
  input  logic              xfer_noclr,
  output logic [N_CH-1:0]   pending
);
  logic [N_CH-1:0] lvl, lvl_q, set_evt, flags, armed, clr_any;
  logic            primed, rd_evt, wr_evt;

  assign rd_evt = reg_cs & ~reg_we;
  assign wr_evt = reg_cs & reg_we;

  irqf_sync #(.N_CH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(irq_in),
    .lvl(lvl), .lvl_q(lvl_q), .primed(primed)
  );

  irqf_detect #(.N_CH(N_CH)) u_det (
    .sense_cfg(sense_cfg), .lvl(lvl), .lvl_q(lvl_q),
    .primed(primed), .set_evt(set_evt)
  );

  irqf_flag_bank #(.N_CH(N_CH)) u_bank (
    .clk(clk), .rst_n(rst_n), .sense_cfg(sense_cfg), .lvl(lvl),
    .set_evt(set_evt), .rd_evt(rd_evt), .wr_evt(wr_evt),
    .wdata(reg_wdata), .cpu_ack(cpu_ack), .xfer_ack(xfer_ack),
    .xfer_noclr(xfer_noclr), .flags(flags), .armed(armed),
    .clr_any(clr_any)
  );

  assign reg_rdata = reg_cs ? flags : '0;
  assign pending   = flags;
endmodule

// File: rtl/irqf_checker.sv
`timescale 1ns/1ps
module irqf_checker #(
  parameter int N_CH = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_CH-1:0] flags,
  input logic [N_CH-1:0] set_evt,
  input logic [N_CH-1:0] clr_any,
  input logic [N_CH-1:0] armed,
  input logic            rd_evt,
  input logic            wr_evt,
  input logic [N_CH-1:0] wdata
);
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt != '0) |=> ((flags & $past(set_evt)) == $past(set_evt))); // R10

  AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(set_evt)) == '0)); // R3

  AST_DROP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flags) & ~flags & ~$past(clr_any)) == '0)); // R6

  AST_ARM_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> ((armed & ~$past(armed)) == '0)); // R6

  AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && (clr_any & wdata & ~set_evt) == '0 && ((flags & wdata) != '0))
      |=> ((flags & $past(flags & wdata)) == $past(flags & wdata))); // R5
endmodule

bind irq_flag_ctrl irqf_checker #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flags(pending), .set_evt(set_evt),
  .clr_any(clr_any), .armed(armed), .rd_evt(rd_evt), .wr_evt(wr_evt),
  .wdata(reg_wdata)
);

// File: tb/irq_flag_ctrl_test.sv
`timescale 1ns/1ps
module irq_flag_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  irq_in;
  logic [15:0] sense_cfg;
  logic        reg_cs, reg_we, xfer_noclr;
  logic [7:0]  reg_wdata, reg_rdata, cpu_ack, xfer_ack, pending;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;   // 250 MHz

  irq_flag_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .sense_cfg(sense_cfg),
    .reg_cs(reg_cs), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_ack(cpu_ack), .xfer_ack(xfer_ack),
    .xfer_noclr(xfer_noclr), .pending(pending)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input int ch, input logic [1:0] m);
    sense_cfg[2*ch +: 2] = m;
  endtask

  task automatic do_read(output logic [7:0] d);
    reg_cs = 1'b1; reg_we = 1'b0;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_cs = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    reg_cs = 1'b1; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_cs = 1'b0; reg_we = 1'b0; reg_wdata = 8'hFF;
  endtask

  task automatic pulse_cpu(input logic [7:0] m);
    cpu_ack = m; @(negedge clk); cpu_ack = '0;
  endtask

  task automatic pulse_xfer(input logic [7:0] m, input logic q);
    xfer_ack = m; xfer_noclr = q; @(negedge clk); xfer_ack = '0; xfer_noclr = 1'b0;
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; step(3); rst_n = 1'b1; step(6);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    irq_in = 8'hFF; sense_cfg = {8{2'b01}};
    apply_reset();
    chk("R1 pending after reset", pending, 8'h00);
    do_read(d);
    chk("R1 read after reset", d, 8'h00);
    irq_in[3] = 1'b0;               // held low through reset, falling mode
    apply_reset();
    chk("R4 no edge from reset", pending, 8'h00);
    irq_in[3] = 1'b1; step(4);
    chk("R4 still clear after release", pending, 8'h00);
  endtask

  task automatic t_level();
    set_mode(0, 2'b00);
    irq_in[0] = 1'b0;
    step(2);
    chk("R2 not yet at two edges", pending, 8'h00);
    step(1);
    chk("R2 level low sets at three edges", pending, 8'h01);
    pulse_cpu(8'h01); step(1);
    chk("R8 ack with input low keeps flag", pending, 8'h01);
    irq_in[0] = 1'b1; step(3);
    chk("R2 flag sticky after input high", pending, 8'h01);
    pulse_cpu(8'h01); step(1);
    chk("R8 ack with input high clears", pending, 8'h00);
    set_mode(0, 2'b01);
  endtask

  task automatic t_edges();
    set_mode(1, 2'b01); set_mode(2, 2'b10); set_mode(3, 2'b11);
    irq_in[3:1] = 3'b000; step(4);
    chk("R3 falling sets fall and both only", pending, 8'h0A);
    irq_in[3:1] = 3'b111; step(4);
    chk("R3 rising adds rise channel", pending, 8'h0E);
    pulse_cpu(8'h0E); step(1);
    chk("R7 exception ack clears edge flags", pending, 8'h00);
    set_mode(3, 2'b11);
    irq_in[3] = 1'b0; step(4);
    pulse_cpu(8'h08); step(1);
    irq_in[3] = 1'b1; step(4);
    chk("R3 both-edge sets on rise too", pending, 8'h08);
    pulse_cpu(8'h08); step(1);
    chk("R7 ack clears both-edge flag", pending, 8'h00);
  endtask

  task automatic t_software();
    logic [7:0] d;
    set_mode(7, 2'b10);
    do_read(d);                     // sees 0: must not arm
    irq_in[7] = 1'b0; step(4); irq_in[7] = 1'b1; step(4);
    chk("R3 rising sets bit 7", pending, 8'h80);
    do_write(8'h00); step(1);
    chk("R6 write 0 after read of 0 keeps flag", pending, 8'h80);
    do_read(d);
    chk("R11 read places channel 7 at bit 7", d, 8'h80);
    do_write(8'hFF); step(1);
    chk("R5 write 1 keeps flag", pending, 8'h80);
    do_write(8'h00); step(1);
    chk("R5 write 1 cancelled read permission", pending, 8'h80);
    do_read(d);
    do_write(8'h7F);
    chk("R11 write acts at next edge", pending, 8'h00);
    chk("R6 guarded write 0 clears", reg_rdata | pending, 8'h00);
  endtask

  task automatic t_xfer();
    irq_in[4] = 1'b0; step(4); irq_in[4] = 1'b1; step(3);
    chk("R3 falling sets channel 4", pending, 8'h10);
    pulse_xfer(8'h10, 1'b1); step(1);
    chk("R9 qualifier high keeps flag", pending, 8'h10);
    pulse_xfer(8'h10, 1'b0); step(1);
    chk("R9 qualifier low clears", pending, 8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    set_mode(5, 2'b00); irq_in[5] = 1'b0; step(4);
    do_read(d);
    chk("R11 read shows level flag", d, 8'h20);
    do_write(8'h00); step(1);
    chk("R10 set beats software clear", pending, 8'h20);
    pulse_xfer(8'h20, 1'b0); step(1);
    chk("R10 set beats transfer clear", pending, 8'h20);
    irq_in[5] = 1'b1; set_mode(5, 2'b01); step(4);
    do_read(d); do_write(8'hDF); step(1);
    chk("R6 clear after input released", pending, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; irq_in = 8'hFF; sense_cfg = {8{2'b01}};
    reg_cs = 1'b0; reg_we = 1'b0; reg_wdata = 8'hFF;
    cpu_ack = '0; xfer_ack = '0; xfer_noclr = 1'b0;
    t_reset();
    t_level();
    t_edges();
    t_software();
    t_xfer();
    t_set_wins();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule